// File: doc/BRIEF.md
# Reload Baud Tick Generator

This block produces the oversampling ticks that pace two serial channels. Each channel has a 10-bit up-counter that starts from a programmable reload value, counts to its all-ones state and reloads. A post-divider turns those overflows into a single-clock tick at sixteen times the channel's bit rate. Channel 0 can take its overflows from an 8-bit auto-reload timer instead of its own counter. A rate-doubling control bit halves channel 0's tick interval for either source.

Software programs each 10-bit reload value through two byte-wide writes. One write carries the upper two bits and the other carries the lower eight. A new value is picked up only when the counter next overflows, so a period that is already running always finishes unchanged. The bit rates follow these formulas: channel 0 gives 2^dbl·f/(64·(1024−r0)), or 2^dbl·f/(384·(256−t)) when it uses the timer; channel 1 gives f/(32·(1024−r1)).

Top module: `baud_tick_gen`

## Requirements
- R1: A write (`cfg_we`=1 at a clock edge) updates one register selected by `cfg_addr`. Address 0 sets reload0[7:0] and address 1 sets reload0[9:8] from `cfg_wdata[1:0]`. Address 2 sets reload1[7:0] and address 3 sets reload1[9:8] from `cfg_wdata[1:0]`. Address 4 sets the timer reload byte t. Address 5 sets control: bit 0 is the doubling bit, bit 1 selects the timer as channel 0's source.
- R2: With the counter source, `tick0` repeats every 4·(1024−reload0) clocks, or every 2·(1024−reload0) clocks when the doubling bit is set.
- R3: `tick1` repeats every 2·(1024−reload1) clocks.
- R4: With the timer source, `tick0` repeats every 24·(256−t) clocks, or every 12·(256−t) clocks when the doubling bit is set.
- R5: A new reload value is loaded only when the counter overflows. If reload1 is rewritten in the cycle of a `tick1`, the next `tick1` interval is N_old+N_new clocks.
- R6: Each tick is high for exactly one clock.
- R7: Reset clears all registers and counters. Both ticks stay low during reset. With no writes after reset, `tick0` repeats every 4096 clocks and `tick1` every 2048 clocks.
- R8: Writes to addresses 6 and 7 change no register, so both tick intervals stay as they were.
- R9: The doubling bit and the channel 0 source select have no effect on `tick1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 8 | Write data |
| tick0 | output | 1 | Channel 0 tick at 16× bit rate |
| tick1 | output | 1 | Channel 1 tick at 16× bit rate |

## Verification
The bench builds the block with its default parameters: a 10-bit reload, an 8-bit timer, post-divide factors of 4, 2 and 24, and a two-stage reset synchronizer. These widths are small enough that the extreme periods fit easily in the run. Those extremes are the 1-clock reload period, the full 1024-clock period left by reset, and the full 256-step timer period. Random configurations with short periods cover the formulas for every source and doubling combination. A write timed on a tick shows that a new reload value takes effect only at the next overflow.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic [2:0] {
    ADR_RLD0_LO = 3'd0,
    ADR_RLD0_HI = 3'd1,
    ADR_RLD1_LO = 3'd2,
    ADR_RLD1_HI = 3'd3,
    ADR_TMR     = 3'd4,
    ADR_CTRL    = 3'd5
  } cfg_addr_e;

  typedef struct packed {
    logic tmr_src;
    logic dbl;
  } ctrl_t;

endpackage

// File: rtl/reload_counter.sv
module reload_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rld,
  output logic         ovf
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign ovf = &cnt_q;

  always_comb begin
    if (ovf) cnt_d = rld;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> cnt_q == $past(cnt_q) + 1'b1); // R5

  AST_LOAD_AT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == $past(rld)); // R5

endmodule

// File: rtl/post_div.sv
module post_div #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ovf_in,
  input  logic [PW-1:0] lim,
  output logic          tick
);

  logic [PW-1:0] post_q;
  logic [PW-1:0] post_d;
  logic          hit;

  assign hit  = post_q >= lim;
  assign tick = ovf_in & hit;

  always_comb begin
    if (hit) post_d = '0;
    else     post_d = post_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      post_q <= '0;
    else if (ovf_in) post_q <= post_d;
  end

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int RLD_W       = 10,
  parameter int TMR_W       = 8,
  parameter int CH0_DIV     = 4,
  parameter int CH1_DIV     = 2,
  parameter int TMR_DIV     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic       tick0,
  output logic       tick1
);

  localparam int HI_W = RLD_W - 8;
  localparam int PW   = $clog2(TMR_DIV);
  localparam logic [PW-1:0] LIM_C0_N = PW'(CH0_DIV - 1);
  localparam logic [PW-1:0] LIM_C0_D = PW'(CH0_DIV / 2 - 1);
  localparam logic [PW-1:0] LIM_T_N  = PW'(TMR_DIV - 1);
  localparam logic [PW-1:0] LIM_T_D  = PW'(TMR_DIV / 2 - 1);
  localparam logic [PW-1:0] LIM_C1   = PW'(CH1_DIV - 1);

  // reset synchronizer
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rs_q[SYNC_STAGES-1];

  // configuration registers
  logic [RLD_W-1:0] rld0_q, rld0_d, rld1_q, rld1_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  ctrl_t            ctrl_q, ctrl_d;

  always_comb begin
    rld0_d = rld0_q;
    rld1_d = rld1_q;
    tmr_d  = tmr_q;
    ctrl_d = ctrl_q;
    case (cfg_addr_e'(cfg_addr))
      ADR_RLD0_LO: rld0_d[7:0]       = cfg_wdata;
      ADR_RLD0_HI: rld0_d[RLD_W-1:8] = cfg_wdata[HI_W-1:0];
      ADR_RLD1_LO: rld1_d[7:0]       = cfg_wdata;
      ADR_RLD1_HI: rld1_d[RLD_W-1:8] = cfg_wdata[HI_W-1:0];
      ADR_TMR:     tmr_d             = cfg_wdata[TMR_W-1:0];
      ADR_CTRL:    ctrl_d            = ctrl_t'(cfg_wdata[1:0]);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rld0_q <= '0;
      rld1_q <= '0;
      tmr_q  <= '0;
      ctrl_q <= '0;
    end else if (cfg_we) begin
      rld0_q <= rld0_d;
      rld1_q <= rld1_d;
      tmr_q  <= tmr_d;
      ctrl_q <= ctrl_d;
    end
  end

  // reload counters
  logic ovf0, ovf1, ovft;

  reload_counter #(.W(RLD_W)) u_cnt0 (
    .clk(clk), .rst_n(rst_s_n), .rld(rld0_q), .ovf(ovf0));
  reload_counter #(.W(RLD_W)) u_cnt1 (
    .clk(clk), .rst_n(rst_s_n), .rld(rld1_q), .ovf(ovf1));
  reload_counter #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .rld(tmr_q), .ovf(ovft));

  // channel 0 source and divide selection
  logic          src_ovf0;
  logic [PW-1:0] lim0;

  always_comb begin
    if (ctrl_q.tmr_src) begin
      src_ovf0 = ovft;
      lim0     = ctrl_q.dbl ? LIM_T_D : LIM_T_N;
    end else begin
      src_ovf0 = ovf0;
      lim0     = ctrl_q.dbl ? LIM_C0_D : LIM_C0_N;
    end
  end

  post_div #(.PW(PW)) u_pd0 (
    .clk(clk), .rst_n(rst_s_n), .ovf_in(src_ovf0), .lim(lim0), .tick(tick0));
  post_div #(.PW(PW)) u_pd1 (
    .clk(clk), .rst_n(rst_s_n), .ovf_in(ovf1), .lim(LIM_C1), .tick(tick1));

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cfg_we |=> $stable(rld1_q) && $stable(rld0_q) && $stable(ctrl_q)); // R1

  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cfg_we && cfg_addr > 3'd5) |=> $stable(rld0_q) && $stable(rld1_q)
      && $stable(tmr_q) && $stable(ctrl_q)); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s_n |-> !tick0 && !tick1); // R7

endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 9000;

  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       tick0, tick1;

  int compared   = 0;
  int mismatched = 0;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .tick0(tick0), .tick1(tick1));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp0(bit src, bit dbl, int r, int t);
    if (src) return (dbl ? 12 : 24) * (256 - t);
    return (dbl ? 2 : 4) * (1024 - r);
  endfunction

  function automatic int exp1(int r);
    return 2 * (1024 - r);
  endfunction

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we    = 1'b1;
    cfg_addr  = 3'(a);
    cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic set_cfg(int r0, int r1, int t, int ctl);
    wr(0, r0 & 8'hFF);
    wr(1, r0 >> 8);
    wr(2, r1 & 8'hFF);
    wr(3, r1 >> 8);
    wr(4, t);
    wr(5, ctl);
  endtask

  task automatic wait_tick(int ch, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if ((ch == 0) ? tick0 : tick1) break;
      if (n >= WAIT_LIMIT) begin
        n = -1;
        break;
      end
    end
  endtask

  task automatic measure(int ch, output int iv);
    int n;
    for (int k = 0; k < 3; k++) wait_tick(ch, n);
    wait_tick(ch, iv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int iv, n, r0, r1, t, ctl;
    void'($urandom(32'd4711));
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 reset ticks low", {30'd0, tick0, tick1}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: defaults after reset
    measure(1, iv); chk("R7 tick1 default", iv, 2048);
    measure(0, iv); chk("R7 tick0 default", iv, 4096);
    @(negedge clk); chk("R6 tick0 one cycle", int'(tick0), 0);

    // R1: high register reaches bits 9:8
    set_cfg(1023, 512, 255, 0);
    measure(1, iv); chk("R1 reload1 high bits", iv, 1024);

    // boundary N=1
    set_cfg(1023, 1023, 255, 0);
    measure(1, iv); chk("R3 reload 1023", iv, 2);
    measure(0, iv); chk("R2 reload 1023", iv, 4);
    wr(5, 1);
    measure(0, iv); chk("R2 reload 1023 doubled", iv, 2);
    wr(5, 2);
    measure(0, iv); chk("R4 timer 255", iv, 24);
    wr(5, 3);
    measure(0, iv); chk("R4 timer 255 doubled", iv, 12);
    wait_tick(1, n); @(negedge clk); chk("R6 tick1 one cycle", int'(tick1), 0);

    // R4: full timer period
    wr(4, 0);
    measure(0, iv); chk("R4 timer 0 doubled", iv, 3072);

    // R5: rewrite reload1 in the cycle of a tick
    set_cfg(1000, 1019, 250, 0);
    measure(1, iv); chk("R3 before change", iv, 10);
    cfg_we = 1'b1; cfg_addr = 3'd2; cfg_wdata = 8'hE2;
    @(negedge clk);
    cfg_we = 1'b0;
    n = 1;
    while (!tick1 && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
    end
    chk("R5 transition interval", n, 35);
    wait_tick(1, iv); chk("R5 new period", iv, 60);

    // R8: unused addresses
    wr(6, 8'hFF);
    wr(7, 8'hFF);
    measure(1, iv); chk("R8 tick1 unchanged", iv, 60);
    measure(0, iv); chk("R8 tick0 unchanged", iv, 4 * 24);

    // R9: channel 1 independent of control
    wr(5, 3);
    measure(1, iv); chk("R9 tick1 with timer and doubling", iv, 60);

    // random configurations
    for (int i = 0; i < 12; i++) begin
      r0  = 1024 - (1 + int'($urandom % 40));
      r1  = 1024 - (1 + int'($urandom % 40));
      t   = 256 - (1 + int'($urandom % 8));
      ctl = int'($urandom % 4);
      set_cfg(r0, r1, t, ctl);
      measure(0, iv);
      chk(((ctl & 2) != 0) ? "R4 random" : "R2 random", iv,
          exp0((ctl & 2) != 0, (ctl & 1) != 0, r0, t));
      measure(1, iv);
      chk("R3 R9 random", iv, exp1(r1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule